// File: doc/BRIEF.md
# Zero-Crossing Triggered Waveform Capture

This block watches a stream of signed audio samples, each announced by a one-cycle ready strobe. It sits idle until the signal rises through zero, meaning a negative sample followed by a non-negative one. From that point it stores a fixed run of samples into an external buffer through a plain write port with address, enable and data. The sample that completes the crossing lands at address 0. When the last address has been written, the block goes back to waiting for the next rising crossing. Each stored trace therefore starts at the same phase of the waveform, which keeps a plotted trace still on screen.

Before a sample is written it is reduced to an unsigned byte that a plot can use directly. The block keeps the upper bits of the sample and inverts the sign bit. This turns two's complement into offset binary, so zero sits at mid-scale and the positive and negative halves of the wave meet without a jump. The controller has two states, waiting and recording, and one address counter. Cycles without the strobe never write and never change the sign history used for crossing detection.

Top module: `zc_capture`

## Requirements
- R1: After synchronous reset (active-high `rst`) the block is waiting, `wr_en` is 0 and `wr_addr` is 0.
- R2: While waiting, a strobed sample with sign bit 0 whose previous strobed sample had sign bit 1 is written in the same cycle at address 0 (the crossing sample itself is the first stored sample), and recording begins.
- R3: On a cycle with `smp_vld` low, `wr_en` is 0, and such cycles do not change the remembered sign of the last strobed sample.
- R4: While waiting, a strobed sample that does not complete a negative-to-non-negative change (positive after positive, negative after positive, negative after negative) causes no write.
- R5: While recording, every strobed sample is written in its own strobe cycle with `wr_en` high for that one cycle, at an address one greater than the previous write.
- R6: The write at address 255 ends the recording. The block returns to waiting, and later strobed samples cause no write until a new rising crossing occurs.
- R7: `wr_data` equals sample bits [15:8] with bit 15 inverted: 0x8000→0x00, 0xFFFF→0x7F, 0x0000→0x80, 0x7FFF→0xFF.
- R8: The remembered sign after reset is non-negative, so a non-negative first sample after reset does not start a recording.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst | input | 1 | Synchronous active-high reset |
| smp_vld | input | 1 | One-cycle strobe marking a new sample |
| smp_in | input | 16 | Signed audio sample |
| wr_en | output | 1 | Buffer write enable |
| wr_addr | output | 8 | Buffer write address |
| wr_data | output | 8 | Offset-binary byte to store |

## Verification
The bench first sends non-negative samples straight after reset, then a positive run, then a negative sample followed by idle cycles that carry positive junk data. These separate a correct reset sign from a wrong one, and strobe-gated sign history from history that updates on every cycle. Exactly zero is used as the crossing sample, so the inclusive non-negative test is checked and the first stored byte is 0x80. The recording mixes back-to-back and gapped strobes, including the extreme codes 0x8000, 0x7FFF and 0xFFFF, so address stepping and the sign-bit conversion are both checked. After the wrap, a positive sample must not retrigger. Only a fresh negative-to-positive pair may start a second recording at address 0.

// File: rtl/zc_capture_pkg.sv
package zc_capture_pkg;

    localparam int SMP_W  = 16;
    localparam int ADDR_W = 8;
    localparam int DATA_W = 8;

    typedef enum logic {
        ST_WAIT = 1'b0,
        ST_REC  = 1'b1
    } cap_state_e;

    typedef struct packed {
        logic              en;
        logic [ADDR_W-1:0] addr;
        logic [DATA_W-1:0] data;
    } wr_req_t;

endpackage

// File: rtl/zc_sign_track.sv
module zc_sign_track #(
    parameter int SMP_W = 16
) (
    input  logic             clk,
    input  logic             rst,
    input  logic             vld,
    input  logic [SMP_W-1:0] smp,
    output logic             rise
);
    logic last_neg;
    logic cur_neg;

    assign cur_neg = smp[SMP_W-1];

    always_ff @(posedge clk) begin
        if (rst)
            last_neg <= 1'b0;
        else if (vld)
            last_neg <= cur_neg;
    end

    assign rise = vld && last_neg && !cur_neg;
endmodule

// File: rtl/zc_convert.sv
module zc_convert #(
    parameter int SMP_W  = 16,
    parameter int DATA_W = 8
) (
    input  logic [SMP_W-1:0]  smp,
    output logic [DATA_W-1:0] byte_out
);
    localparam int LOW = SMP_W - DATA_W;

    always_comb begin
        byte_out              = smp[SMP_W-1:LOW];
        byte_out[DATA_W-1]    = ~smp[SMP_W-1];
    end
endmodule

// File: rtl/zc_addr_ctr.sv
module zc_addr_ctr #(
    parameter int ADDR_W = 8
) (
    input  logic              clk,
    input  logic              rst,
    input  logic              clr,
    input  logic              inc,
    output logic [ADDR_W-1:0] addr,
    output logic              at_top
);
    localparam logic [ADDR_W-1:0] TOP = {ADDR_W{1'b1}};

    always_ff @(posedge clk) begin
        if (rst || clr)
            addr <= '0;
        else if (inc)
            addr <= addr + 1'b1;
    end

    assign at_top = (addr == TOP);
endmodule

// File: rtl/zc_ctrl.sv
module zc_ctrl
    import zc_capture_pkg::*;
(
    input  logic       clk,
    input  logic       rst,
    input  logic       vld,
    input  logic       rise,
    input  logic       at_top,
    output cap_state_e state,
    output logic       we,
    output logic       inc,
    output logic       clr
);
    cap_state_e nxt;

    always_comb begin
        nxt = state;
        we  = 1'b0;
        inc = 1'b0;
        clr = 1'b0;
        unique case (state)
            ST_WAIT: begin
                if (rise) begin
                    we  = 1'b1;
                    inc = 1'b1;
                    nxt = ST_REC;
                end else begin
                    clr = 1'b1;
                end
            end
            ST_REC: begin
                if (vld) begin
                    we  = 1'b1;
                    inc = 1'b1;
                    if (at_top)
                        nxt = ST_WAIT;
                end
            end
            default: nxt = ST_WAIT;
        endcase
    end

    always_ff @(posedge clk) begin
        if (rst)
            state <= ST_WAIT;
        else
            state <= nxt;
    end
endmodule

// File: rtl/zc_capture.sv
module zc_capture
    import zc_capture_pkg::*;
#(
    parameter int SMP_W_P  = SMP_W,
    parameter int ADDR_W_P = ADDR_W,
    parameter int DATA_W_P = DATA_W
) (
    input  logic                clk,
    input  logic                rst,
    input  logic                smp_vld,
    input  logic [SMP_W_P-1:0]  smp_in,
    output logic                wr_en,
    output logic [ADDR_W_P-1:0] wr_addr,
    output logic [DATA_W_P-1:0] wr_data
);
    cap_state_e          cur_state;
    logic                rise;
    logic                at_top;
    logic                ctr_inc;
    logic                ctr_clr;
    logic                we_int;
    logic [ADDR_W_P-1:0] ctr_addr;
    logic [DATA_W_P-1:0] conv_byte;

    zc_sign_track #(.SMP_W(SMP_W_P)) u_sign (
        .clk  (clk),
        .rst  (rst),
        .vld  (smp_vld),
        .smp  (smp_in),
        .rise (rise)
    );

    zc_convert #(.SMP_W(SMP_W_P), .DATA_W(DATA_W_P)) u_conv (
        .smp      (smp_in),
        .byte_out (conv_byte)
    );

    zc_addr_ctr #(.ADDR_W(ADDR_W_P)) u_ctr (
        .clk    (clk),
        .rst    (rst),
        .clr    (ctr_clr),
        .inc    (ctr_inc),
        .addr   (ctr_addr),
        .at_top (at_top)
    );

    zc_ctrl u_ctrl (
        .clk    (clk),
        .rst    (rst),
        .vld    (smp_vld),
        .rise   (rise),
        .at_top (at_top),
        .state  (cur_state),
        .we     (we_int),
        .inc    (ctr_inc),
        .clr    (ctr_clr)
    );

    assign wr_en   = we_int;
    assign wr_addr = ctr_addr;
    assign wr_data = conv_byte;
endmodule

// File: rtl/zc_capture_chk.sv
module zc_capture_chk
    import zc_capture_pkg::*;
(
    input logic        clk,
    input logic        rst,
    input logic        smp_vld,
    input logic [15:0] smp_in,
    input logic        wr_en,
    input logic [7:0]  wr_addr,
    input logic [7:0]  wr_data,
    input cap_state_e  st
);
    // R1
    wait_addr_zero_chk: assert property (@(posedge clk) disable iff (rst)
        (st == ST_WAIT) |-> (wr_addr == 8'd0));

    // R2
    first_write_chk: assert property (@(posedge clk) disable iff (rst)
        (st == ST_WAIT && wr_en) |-> (!smp_in[15] && wr_addr == 8'd0) ##1 (st == ST_REC));

    // R3
    no_strobe_no_write_chk: assert property (@(posedge clk) disable iff (rst)
        !smp_vld |-> !wr_en);

    // R5
    rec_writes_chk: assert property (@(posedge clk) disable iff (rst)
        (st == ST_REC && smp_vld) |-> wr_en);

    // R5
    addr_step_chk: assert property (@(posedge clk) disable iff (rst)
        (wr_en && wr_addr != 8'hFF) |=> (st == ST_REC && wr_addr == $past(wr_addr) + 8'd1));

    // R6
    wrap_rearm_chk: assert property (@(posedge clk) disable iff (rst)
        (wr_en && wr_addr == 8'hFF) |=> (st == ST_WAIT));

    // R7
    data_map_chk: assert property (@(posedge clk) disable iff (rst)
        wr_en |-> (wr_data[7] != smp_in[15] && wr_data[6:0] == smp_in[14:8]));
endmodule

bind zc_capture zc_capture_chk u_chk (
    .clk     (clk),
    .rst     (rst),
    .smp_vld (smp_vld),
    .smp_in  (smp_in),
    .wr_en   (wr_en),
    .wr_addr (wr_addr),
    .wr_data (wr_data),
    .st      (cur_state)
);

// File: tb/zc_capture_tb.sv
module zc_capture_tb;
    localparam int CLK_PERIOD = 10;

    typedef struct {
        logic       we;
        logic [7:0] addr;
        logic [7:0] data;
        string      tag;
    } exp_t;

    logic        clk = 1'b0;
    logic        rst = 1'b1;
    logic        smp_vld = 1'b0;
    logic [15:0] smp_in = 16'h0;
    logic        wr_en;
    logic [7:0]  wr_addr;
    logic [7:0]  wr_data;

    int checks = 0;
    int fails  = 0;
    exp_t q[$];

    bit         m_wait = 1'b1;
    bit         m_prev_neg = 1'b0;
    logic [7:0] m_ctr = 8'd0;

    always #(CLK_PERIOD/2) clk = ~clk;

    zc_capture u_dut (
        .clk     (clk),
        .rst     (rst),
        .smp_vld (smp_vld),
        .smp_in  (smp_in),
        .wr_en   (wr_en),
        .wr_addr (wr_addr),
        .wr_data (wr_data)
    );

    function automatic logic [7:0] off_byte(input logic [15:0] s);
        logic [16:0] t;
        t = {1'b0, s} + 17'h08000;
        return t[15:8];
    endfunction

    task automatic send(input logic [15:0] s, input string tag);
        exp_t e;
        bit neg;
        neg = s[15];
        e.we = 1'b0; e.addr = 8'd0; e.data = 8'd0; e.tag = tag;
        if (m_wait) begin
            if (m_prev_neg && !neg) begin
                e.we = 1'b1; e.addr = 8'd0; e.data = off_byte(s);
                m_wait = 1'b0; m_ctr = 8'd1;
            end
        end else begin
            e.we = 1'b1; e.addr = m_ctr; e.data = off_byte(s);
            if (m_ctr == 8'hFF) m_wait = 1'b1;
            m_ctr = m_ctr + 8'd1;
        end
        m_prev_neg = neg;
        @(posedge clk); #1;
        smp_in  = s;
        smp_vld = 1'b1;
        q.push_back(e);
    endtask

    task automatic idle(input int n);
        for (int k = 0; k < n; k++) begin
            @(posedge clk); #1;
            smp_vld = 1'b0;
            smp_in  = 16'h4000 + 16'(k);
        end
    endtask

    task automatic chk(input bit ok, input string tag, input string what,
                       input int act, input int exp);
        checks++;
        if (!ok) begin
            fails++;
            $display("FAIL %s %s actual=%0h expected=%0h", tag, what, act, exp);
        end
    endtask

    // monitor: compares the write port against the queue away from the edge
    initial begin
        exp_t e;
        forever begin
            @(negedge clk);
            if (!rst) begin
                if (smp_vld) begin
                    if (q.size() == 0) begin
                        chk(1'b0, "R5", "strobe without expectation", 0, 1);
                    end else begin
                        e = q.pop_front();
                        chk(wr_en == e.we, e.tag, "wr_en", int'(wr_en), int'(e.we));
                        if (e.we && wr_en) begin
                            chk(wr_addr == e.addr, e.tag, "wr_addr", int'(wr_addr), int'(e.addr));
                            chk(wr_data == e.data, "R7", "wr_data", int'(wr_data), int'(e.data));
                        end
                    end
                end else begin
                    chk(wr_en == 1'b0, "R3", "wr_en without strobe", int'(wr_en), 0);
                end
            end
        end
    end

    initial begin
        repeat (100000) @(posedge clk);
        fails++;
        checks++;
        $display("FAIL watchdog actual=timeout expected=done");
        $display("%0d/%0d checks passed", checks - fails, checks);
        $finish;
    end

    initial begin
        repeat (3) @(posedge clk);
        #1;
        chk(wr_en == 1'b0, "R1", "wr_en in reset", int'(wr_en), 0);
        @(posedge clk); #1;
        rst = 1'b0;
        @(negedge clk);
        chk(wr_en == 1'b0, "R1", "wr_en after reset", int'(wr_en), 0);
        chk(wr_addr == 8'd0, "R1", "wr_addr after reset", int'(wr_addr), 0);

        send(16'h1000, "R8");
        send(16'h2000, "R4");
        idle(1);
        send(16'h7FFF, "R4");
        send(16'hF000, "R4");
        send(16'hC000, "R4");
        idle(3);
        send(16'h0000, "R2");
        send(16'h8000, "R5");
        send(16'h7FFF, "R5");
        send(16'hFFFF, "R5");
        for (int i = 4; i < 256; i++) begin
            send(16'(i * 263), (i == 255) ? "R6" : "R5");
            if (i % 17 == 0) idle(2);
        end
        idle(2);
        send(16'h3000, "R6");
        send(16'h0100, "R6");
        idle(1);
        send(16'h9000, "R4");
        idle(2);
        send(16'h0200, "R2");
        for (int i = 1; i < 6; i++) send(16'(i * 4099), "R5");
        idle(3);

        chk(q.size() == 0, "R5", "pending expectations", q.size(), 0);
        $display("%0d/%0d checks passed", checks - fails, checks);
        $finish;
    end
endmodule